// File: doc/BRIEF.md
# Multichannel PWM Timer with a Shared Counter

This block is a register-programmed pulse-width modulation timer. One 16-bit up-counter, driven through a power-of-two prescaler, is shared by a set of output channels. Software sets the counting mode, the prescale factor and the period through a small synchronous register bus. It then gives each channel a control word and a compare value. Every channel drives one PWM pin and keeps a sticky match flag.

The counter counts from zero up to the period value and then returns to zero. The period and the compare values are double-buffered while the counter runs, and a buffered value takes effect at that return to zero. This keeps a running waveform free of glitches. While the counter is stopped, writes take effect at once. The prescale factor is locked while the counter runs. A second period write is dropped while an earlier one is still waiting to load.

Register offsets: control at 0x10, counter at 0x14, period at 0x18. Channel n has its control word at 0x20+8n and its compare value at 0x24+8n. Reads are combinational from the address, and an unmapped address reads zero.

Top module: `pwmt_top`

## Requirements
- R1: After reset the control register, counter, channel controls and compare values read 0, the period reads 0xFFFF, and every PWM output is low.
- R2: Control bits [4:3] select the counting mode. 00 stops the counter, which then holds its value. 01 makes it advance once per prescaled clock.
- R3: Control bits [2:0] hold a prescale exponent P. While the counter is running it advances once every 2^P clock cycles, with the first advance on cycle 2^P after the run starts.
- R4: A write to bits [2:0] of the control register takes effect only when the mode read before the write is 00. Otherwise the exponent keeps its old value, while bits [5:3] are still written.
- R5: On the prescaled clock on which the counter equals the period, it goes to zero instead of advancing. Any write to the counter register sets it to zero.
- R6: A period write made while the mode is 00 replaces the active period at once, and clears any waiting value.
- R7: A period write made while the mode is not 00 is held and loads when the counter goes back to zero. A further period write made while a value is still held is ignored.
- R8: A compare write made while the mode is 00 loads at once. Otherwise it is held, and the latest held value loads when the counter goes back to zero.
- R9: In a channel control word, bits [5:4] select the mode and bits [3:2] the output level. With bit 5 set and level 10, the output is high while the counter is below the compare value. Level 11 inverts that output. Level 00, or bit 5 clear, holds the output low.
- R10: A compare value of zero gives a constant inactive output. A compare value above the period gives a constant active output.
- R11: Bit 7 of a channel control word is a flag. It sets on a prescaled clock while the counter equals the compare value. Writing 1 to bit 7 clears it, and a set in the same cycle wins over the clear.
- R12: Channels share the counter and period but keep separate controls, compare values and outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Two collisions are provoked on purpose. In the first, a flag-clearing write is timed to land on the exact prescaled clock on which the counter matches the compare value. The flag must read back as set. In the second, two period writes are made back to back while the counter runs with the slowest prescaler. The first write must load at the next return to zero, and the second must never appear, even after a further wrap. The PWM shapes are judged cycle by cycle: on each cycle the bench reads the counter through the bus and compares the pin against the counter and the compare value.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int PS_W    = 3;
    localparam int PRE_W   = (1 << PS_W) - 1;
    localparam int MAX_CH  = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PERIOD  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CH_CTL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CH_CMP  = 8'h24;
    localparam int                CH_STRIDE   = 8;

    typedef enum logic [1:0] {
        CM_STOP = 2'b00,
        CM_RUN  = 2'b01,
        CM_RSV2 = 2'b10,
        CM_RSV3 = 2'b11
    } cmode_e;

    typedef struct packed {
        logic           center;
        cmode_e         cmod;
        logic [PS_W-1:0] ps;
    } tmr_ctrl_t;

    typedef struct packed {
        logic [1:0] msel;
        logic [1:0] lvl;
    } ch_mode_t;

    function automatic logic pwm_level(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] cmp,
                                       input ch_mode_t         md);
        logic raw;
        raw = (cnt < cmp);
        if (!md.msel[1] || md.lvl == 2'b00)
            return 1'b0;
        return md.lvl[0] ? ~raw : raw;
    endfunction

    function automatic logic [PRE_W-1:0] pre_mask(input logic [PS_W-1:0] ps);
        return PRE_W'({PRE_W{1'b1}} >> (PS_W'(PRE_W) - ps));
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  tmr_ctrl_t        ctrl_wdata,
    input  logic             cnt_clr,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output tmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] per_q,
    output logic             tick,
    output logic             wrap,
    output logic             stopped
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [CNT_W-1:0] per_buf_q;
    logic             per_pend_q;
    logic             running;

    assign running = (ctrl_q.cmod == CM_RUN);
    assign stopped = (ctrl_q.cmod == CM_STOP);
    assign mask    = pre_mask(ctrl_q.ps);
    assign tick    = running && ((pre_q & mask) == mask);
    assign wrap    = tick && (cnt_q == per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.center <= ctrl_wdata.center;
            ctrl_q.cmod   <= ctrl_wdata.cmod;
            if (ctrl_q.cmod == CM_STOP)
                ctrl_q.ps <= ctrl_wdata.ps;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!running || cnt_clr)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
            if (cnt_clr)
                cnt_q <= '0;
            else if (wrap)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q      <= {CNT_W{1'b1}};
            per_buf_q  <= '0;
            per_pend_q <= 1'b0;
        end else if (per_we && stopped) begin
            per_q      <= per_wdata;
            per_pend_q <= 1'b0;
        end else begin
            if (wrap && per_pend_q) begin
                per_q      <= per_buf_q;
                per_pend_q <= 1'b0;
            end
            if (per_we && !per_pend_q) begin
                per_buf_q  <= per_wdata;
                per_pend_q <= 1'b1;
            end
        end
    end

    AST_PS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cmod != CM_STOP) |=> $stable(ctrl_q.ps)); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !cnt_clr) |=> $stable(cnt_q)); // R2
    AST_UNDIV_TICK: assert property (@(posedge clk) disable iff (rst)
        (running && ctrl_q.ps == '0) |-> tick); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap && !cnt_clr) |=> (cnt_q == '0)); // R5
    AST_HELD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (per_pend_q && !wrap && !stopped) |=> $stable(per_q)); // R7

endmodule

// File: rtl/pwmt_channel.sv
`timescale 1ns/1ps
module pwmt_channel
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             stopped,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       ctl_rdata,
    output logic [CNT_W-1:0] cmp_q,
    output logic             pwm_o
);

    ch_mode_t         mode_q;
    logic             flag_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic             cmp_pend_q;
    logic             hit;
    logic             unused_ctl_bits;

    assign unused_ctl_bits = ^{ctl_wdata[6], ctl_wdata[1:0]};
    assign hit = tick && (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctl_we)
                mode_q <= ch_mode_t'(ctl_wdata[5:2]);
            if (hit)
                flag_q <= 1'b1;
            else if (ctl_we && ctl_wdata[7])
                flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q      <= '0;
            cmp_buf_q  <= '0;
            cmp_pend_q <= 1'b0;
        end else if (cmp_we && stopped) begin
            cmp_q      <= cmp_wdata;
            cmp_pend_q <= 1'b0;
        end else begin
            if (wrap && cmp_pend_q) begin
                cmp_q      <= cmp_buf_q;
                cmp_pend_q <= 1'b0;
            end
            if (cmp_we) begin
                cmp_buf_q  <= cmp_wdata;
                cmp_pend_q <= 1'b1;
            end
        end
    end

    assign pwm_o     = pwm_level(cnt, cmp_q, mode_q);
    assign ctl_rdata = {flag_q, 1'b0, mode_q, 2'b00};

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q); // R11
    AST_LEVEL_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q.lvl == 2'b00 || !mode_q.msel[1]) |-> !pwm_o); // R9
    AST_ZERO_CMP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmp_q == '0 && mode_q.lvl == 2'b10) |-> !pwm_o); // R10
    AST_CMP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !(cmp_we && stopped)) |=> $stable(cmp_q)); // R8

endmodule

// File: rtl/pwmt_top.sv
`timescale 1ns/1ps
module pwmt_top
    import pwmt_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic             tick;
    logic             wrap;
    logic             stopped;

    logic [NUM_CH-1:0]           ctl_we;
    logic [NUM_CH-1:0]           cmp_we;
    logic [NUM_CH-1:0][7:0]      ctl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_rd;

    pwmt_counter u_counter (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (bus_wr && bus_addr == OFS_CTRL),
        .ctrl_wdata (tmr_ctrl_t'(bus_wdata[5:0])),
        .cnt_clr    (bus_wr && bus_addr == OFS_COUNT),
        .per_we     (bus_wr && bus_addr == OFS_PERIOD),
        .per_wdata  (bus_wdata),
        .ctrl_q     (ctrl_q),
        .cnt_q      (cnt_q),
        .per_q      (per_q),
        .tick       (tick),
        .wrap       (wrap),
        .stopped    (stopped)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(OFS_CH_CTL + CH_STRIDE * g);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(OFS_CH_CMP + CH_STRIDE * g);

        assign ctl_we[g] = bus_wr && (bus_addr == CTL_A);
        assign cmp_we[g] = bus_wr && (bus_addr == CMP_A);

        pwmt_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .ctl_we    (ctl_we[g]),
            .ctl_wdata (bus_wdata[7:0]),
            .cmp_we    (cmp_we[g]),
            .cmp_wdata (bus_wdata),
            .stopped   (stopped),
            .tick      (tick),
            .wrap      (wrap),
            .cnt       (cnt_q),
            .ctl_rdata (ctl_rd[g]),
            .cmp_q     (cmp_rd[g]),
            .pwm_o     (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:   bus_rdata = {10'd0, ctrl_q};
            OFS_COUNT:  bus_rdata = cnt_q;
            OFS_PERIOD: bus_rdata = per_q;
            default:    bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFS_CH_CTL + CH_STRIDE * i))
                bus_rdata = {8'd0, ctl_rd[i]};
            if (bus_addr == ADDR_W'(OFS_CH_CMP + CH_STRIDE * i))
                bus_rdata = cmp_rd[i];
        end
    end

    AST_CH_COUNT_OK: assert property (@(posedge clk) disable iff (rst)
        (NUM_CH >= 1 && NUM_CH <= MAX_CH)); // R12

endmodule

// File: tb/pwmt_top_bench.sv
`timescale 1ns/1ps
module pwmt_top_bench;

    localparam int NCH = 2;
    localparam logic [7:0] A_CTRL = 8'h10, A_CNT = 8'h14, A_PER = 8'h18;
    localparam logic [7:0] A_C0CTL = 8'h20, A_C0CMP = 8'h24;
    localparam logic [7:0] A_C1CTL = 8'h28, A_C1CMP = 8'h2C;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwmt_top #(.NUM_CH(NCH)) u_pwmt_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_CNT, v);   check("R1 count", v, 0);
        rd(A_PER, v);   check("R1 period", v, 16'hFFFF);
        rd(A_C0CTL, v); check("R1 ch0 ctl", v, 0);
        rd(A_C1CMP, v); check("R1 ch1 cmp", v, 0);
        check("R1 outputs", int'(pwm_out), 0);
    endtask

    task automatic t_prescale();
        int v, a;
        wr(A_CTRL, 16'h0000); wr(A_CNT, 0); wr(A_PER, 16'hFFFF);
        wr(A_CTRL, 16'h000A);
        idle(40);
        rd(A_CNT, v); check("R3 ps=2 count after 40", v, 10);
        wr(A_CTRL, 16'h0008);
        rd(A_CTRL, v); check("R4 ps kept while running", v, 16'h000A);
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, v); check("R4 ps kept on stop write", v, 16'h0002);
        rd(A_CNT, a); idle(6);
        rd(A_CNT, v); check("R2 stopped counter holds", v, a);
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, v); check("R4 ps written when stopped", v, 0);
        wr(A_CNT, 0); wr(A_CTRL, 16'h0008);
        idle(13);
        rd(A_CNT, v); check("R2 ps=0 count after 13", v, 13);
    endtask

    task automatic t_wrap();
        int v;
        wr(A_CTRL, 0); wr(A_PER, 4);
        rd(A_PER, v); check("R6 period immediate", v, 4);
        wr(A_CNT, 0); wr(A_CTRL, 16'h0008);
        idle(7);
        rd(A_CNT, v); check("R5 count after 7 (period 4)", v, 2);
        idle(5);
        rd(A_CNT, v); check("R5 count after 12", v, 2);
        wr(A_CNT, 0);
        rd(A_CNT, v); check("R5 counter write clears", v, 0);
    endtask

    task automatic t_period_buffer();
        int v;
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_PER, 4);
        wr(A_CTRL, 16'h000F);
        wr(A_PER, 9);
        wr(A_PER, 2);
        rd(A_PER, v); check("R7 period not loaded before wrap", v, 4);
        idle(700);
        rd(A_PER, v); check("R7 held period loaded at wrap", v, 9);
        idle(1400);
        rd(A_PER, v); check("R7 second write ignored", v, 9);
    endtask

    task automatic t_cmp_buffer();
        int v;
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_C0CMP, 3);
        rd(A_C0CMP, v); check("R8 compare immediate when stopped", v, 3);
        wr(A_CTRL, 16'h000F);
        wr(A_C0CMP, 1);
        rd(A_C0CMP, v); check("R8 compare held while running", v, 3);
        idle(1400);
        rd(A_C0CMP, v); check("R8 compare loaded at wrap", v, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_shapes();
        int c, v;
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_PER, 9);
        wr(A_C0CTL, 16'h00A8); wr(A_C0CMP, 4);
        wr(A_C1CTL, 16'h00AC); wr(A_C1CMP, 7);
        wr(A_CTRL, 16'h0008);
        for (int i = 0; i < 25; i++) begin
            rd(A_CNT, c);
            check("R9 ch0 high below compare", int'(pwm_out[0]), (c < 4) ? 1 : 0);
            check("R12 ch1 inverted own compare", int'(pwm_out[1]), (c < 7) ? 0 : 1);
            @(negedge clk);
        end
        rd(A_C0CTL, v); check("R11 flag set after match", v, 16'h00A8);
        wr(A_C0CTL, 16'h0018); wr(A_C1CTL, 16'h0020);
        for (int i = 0; i < 12; i++) begin
            check("R9 msel clear / level 00 low", int'(pwm_out), 0);
            @(negedge clk);
        end
        wr(A_CTRL, 0); wr(A_CNT, 0);
        wr(A_C0CTL, 16'h0028); wr(A_C0CMP, 0);
        wr(A_C1CTL, 16'h0028); wr(A_C1CMP, 10);
        wr(A_CTRL, 16'h0008);
        for (int i = 0; i < 22; i++) begin
            check("R10 zero compare inactive", int'(pwm_out[0]), 0);
            check("R10 compare above period active", int'(pwm_out[1]), 1);
            @(negedge clk);
        end
    endtask

    task automatic t_flag_collide();
        int v;
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_PER, 9);
        wr(A_C0CMP, 3); wr(A_C0CTL, 16'h00A8);
        rd(A_C0CTL, v); check("R11 w1c clears flag", v, 16'h0028);
        wr(A_CTRL, 16'h0008);
        idle(3);
        wr(A_C0CTL, 16'h00A8);
        rd(A_C0CTL, v); check("R11 set wins over clear", v, 16'h00A8);
        wr(A_CTRL, 0);
        wr(A_C0CTL, 16'h00A8);
        rd(A_C0CTL, v); check("R11 clear after collision", v, 16'h0028);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_wrap();
        t_period_buffer();
        t_cmp_buffer();
        t_shapes();
        t_flag_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule